// File: doc/BRIEF.md
# Compare and Branch Condition Unit

This unit keeps the processor's condition state and decides where control flow goes next. A compare strobe compares two 16-bit operands as signed two's complement numbers. It stores the result in two registered flags: one for less-than and one for greater-than. Equality is not stored. It is the case where neither flag is set.

A 3-bit select picks one of eight conditions, all derived from the two flags. Each cycle the unit can resolve one of two request types:

- a conditional relative branch, which adds a signed 8-bit displacement to the incremented PC;
- a conditional jump, which goes to a full 16-bit register value.

Both outputs, the taken flag and the next PC, are combinational from the current inputs and the stored flags. A branch in the same cycle as a compare therefore acts on the flags from before that compare.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset both flags are clear, so the eq condition (select 3) holds until the first compare.
- R2: When the compare strobe is high at a clock edge, the less-than flag becomes (a < b) and the greater-than flag becomes (a > b). Both operands are read as signed 16-bit values, so 0x8000 is below 0x7FFF.
- R3: When the compare strobe is low at a clock edge, neither flag changes, whatever the operand values.
- R4: A branch or jump in the same cycle as a compare uses the flags held before that compare's edge.
- R5: The select encodes the conditions as follows: 0 never, 1 lt, 2 le, 3 eq, 4 ne, 5 ge, 6 gt, 7 always. Here lt = LT, gt = GT, eq = !LT & !GT, le = lt | eq, ge = gt | eq, and ne = !eq.
- R6: The taken output is high only when a branch or jump request is present and the selected condition is true.
- R7: A taken relative branch sets next PC to PC + 1 + sign_extend(offset), modulo 2^16.
- R8: A taken register jump sets next PC to the full 16-bit register target.
- R9: When nothing is taken, next PC is PC + 1, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R10: If both a branch and a jump are requested in the same cycle, the jump's register target is used when taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_en | input | 1 | Compare strobe; flags update at this edge |
| opnd_a | input | 16 | First compare operand (signed) |
| opnd_b | input | 16 | Second compare operand (signed) |
| br_req | input | 1 | Conditional relative branch request |
| jr_req | input | 1 | Conditional register jump request |
| cond_sel | input | 3 | Condition select (encoding in R5) |
| br_off | input | 8 | Signed branch displacement |
| jr_target | input | 16 | Register jump destination |
| pc | input | 16 | Current program counter |
| taken | output | 1 | Control transfer taken |
| next_pc | output | 16 | Address of the next instruction |

## Verification
The embedded assertions check several properties on every cycle:

- the two flags are never set together;
- the flags hold when the strobe is low, and follow the signed comparison when it is high;
- no request never produces a taken result;
- a not-taken cycle always yields PC + 1;
- a taken jump always yields the register target.

The bench scenarios cover the rest:

- the full eight-entry condition table under each flag state;
- the signed boundary between 0x8000 and 0x7FFF;
- displacement extremes and PC wrap;
- the same-cycle ordering of a compare and a branch;
- the priority when both requests are present.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    localparam int DATA_W = 16;
    localparam int OFF_W  = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        C_NEVER  = 3'd0,
        C_LT     = 3'd1,
        C_LE     = 3'd2,
        C_EQ     = 3'd3,
        C_NE     = 3'd4,
        C_GE     = 3'd5,
        C_GT     = 3'd6,
        C_ALWAYS = 3'd7
    } cond_e;

    typedef struct packed {
        logic lt;
        logic gt;
    } flags_t;
endpackage

// File: rtl/cbu_compare.sv
module cbu_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output cbu_pkg::flags_t res
);
    always_comb begin
        res.lt = $signed(a) < $signed(b);
        res.gt = $signed(a) > $signed(b);
    end

    always_comb begin
        a_r2_exclusive: assert (!(res.lt && res.gt));
    end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval #(
    parameter int SW = 3
) (
    input  cbu_pkg::flags_t flags,
    input  logic [SW-1:0]   sel,
    output logic            cond_true
);
    import cbu_pkg::*;

    logic eq;

    always_comb begin
        eq = !flags.lt && !flags.gt;
        case (cond_e'(sel))
            C_NEVER:  cond_true = 1'b0;
            C_LT:     cond_true = flags.lt;
            C_LE:     cond_true = flags.lt || eq;
            C_EQ:     cond_true = eq;
            C_NE:     cond_true = !eq;
            C_GE:     cond_true = flags.gt || eq;
            C_GT:     cond_true = flags.gt;
            C_ALWAYS: cond_true = 1'b1;
            default:  cond_true = 1'b0;
        endcase
    end

    always_comb begin
        a_r5_never_always: assert (!(sel == C_NEVER && cond_true) && !(sel == C_ALWAYS && !cond_true));
    end
endmodule

// File: rtl/cbu_target.sv
module cbu_target #(
    parameter int W  = 16,
    parameter int OW = 8
) (
    input  logic          take,
    input  logic          use_reg,
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] off,
    input  logic [W-1:0]  reg_tgt,
    output logic [W-1:0]  npc
);
    localparam int EXT_W = W - OW;

    logic [W-1:0] seq_pc;
    logic [W-1:0] off_ext;

    always_comb begin
        seq_pc  = pc + W'(1);
        off_ext = {{EXT_W{off[OW-1]}}, off};
        if (!take)
            npc = seq_pc;
        else if (use_reg)
            npc = reg_tgt;
        else
            npc = seq_pc + off_ext;
    end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
    parameter int DATA_W = cbu_pkg::DATA_W,
    parameter int OFF_W  = cbu_pkg::OFF_W,
    parameter int SEL_W  = cbu_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              br_req,
    input  logic              jr_req,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [DATA_W-1:0] jr_target,
    input  logic [DATA_W-1:0] pc,
    output logic              taken,
    output logic [DATA_W-1:0] next_pc
);
    import cbu_pkg::*;

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;
    flags_t cmp_res;
    logic   cond_true;
    logic   any_req;

    cbu_compare #(.W(DATA_W)) u_cmp (
        .a   (opnd_a),
        .b   (opnd_b),
        .res (cmp_res)
    );

    cbu_cond_eval #(.SW(SEL_W)) u_eval (
        .flags     (state_q.flags),
        .sel       (cond_sel),
        .cond_true (cond_true)
    );

    always_comb begin
        state_d = state_q;
        if (cmp_en)
            state_d.flags = cmp_res;
        any_req = br_req || jr_req;
        taken   = any_req && cond_true;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    cbu_target #(.W(DATA_W), .OW(OFF_W)) u_tgt (
        .take    (taken),
        .use_reg (jr_req),
        .pc      (pc),
        .off     (br_off),
        .reg_tgt (jr_target),
        .npc     (next_pc)
    );

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(state_q.flags));

    a_r2_signed_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> (state_q.flags.lt == $past($signed(opnd_a) < $signed(opnd_b))) &&
                   (state_q.flags.gt == $past($signed(opnd_a) > $signed(opnd_b))));

    a_r6_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_req || jr_req) |-> !taken);

    a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> next_pc == pc + DATA_W'(1));

    a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && jr_req) |-> next_pc == jr_target);
endmodule

// File: tb/cond_branch_unit_tb_top.sv
module cond_branch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_en = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        br_req = 1'b0, jr_req = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic [7:0]  br_off = '0;
    logic [15:0] jr_target = '0, pc = '0;
    logic        taken;
    logic [15:0] next_pc;

    int n_run = 0;
    int n_fail = 0;
    logic m_lt = 1'b0, m_gt = 1'b0;

    always #10 clk = ~clk;

    cond_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .br_req(br_req), .jr_req(jr_req), .cond_sel(cond_sel), .br_off(br_off),
        .jr_target(jr_target), .pc(pc), .taken(taken), .next_pc(next_pc)
    );

    function automatic logic f_cond(input logic [2:0] s, input logic lt, input logic gt);
        logic eq;
        eq = !lt && !gt;
        case (s)
            3'd0: return 1'b0;
            3'd1: return lt;
            3'd2: return lt || eq;
            3'd3: return eq;
            3'd4: return !eq;
            3'd5: return gt || eq;
            3'd6: return gt;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] f_npc(input logic tk, input logic jr, input logic [15:0] p,
                                          input logic [7:0] o, input logic [15:0] t);
        if (!tk) return p + 16'd1;
        if (jr) return t;
        return p + 16'd1 + {{8{o[7]}}, o};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, check mid-low phase, flags commit at next posedge
    task automatic step(input logic ce, input logic [15:0] a, input logic [15:0] b,
                        input logic br, input logic jr, input logic [2:0] s,
                        input logic [7:0] o, input logic [15:0] t, input logic [15:0] p,
                        input string req);
        logic etk;
        @(negedge clk);
        cmp_en = ce; opnd_a = a; opnd_b = b; br_req = br; jr_req = jr;
        cond_sel = s; br_off = o; jr_target = t; pc = p;
        #5;
        etk = (br || jr) && f_cond(s, m_lt, m_gt);
        check({req, " taken"}, {15'd0, taken}, {15'd0, etk});
        check({req, " next_pc"}, next_pc, f_npc(etk, jr, p, o, t));
        @(posedge clk);
        if (ce) begin
            m_lt = $signed(a) < $signed(b);
            m_gt = $signed(a) > $signed(b);
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #35;
        // reset state: flags clear -> eq true (R1), no request (R6)
        #1;
        check("R1 reset taken", {15'd0, taken}, 16'd0);
        rst_n = 1'b1;
        step(0, 0, 0, 1, 0, 3'd3, 8'h05, 0, 16'h0100, "R1 eq after reset");
        step(0, 0, 0, 1, 0, 3'd4, 8'h05, 0, 16'h0100, "R1 ne after reset");
        step(0, 0, 0, 0, 0, 3'd7, 8'h05, 0, 16'h0200, "R6 no request");
        // R2 signed boundary: 0x8000 < 0x7FFF
        step(1, 16'h8000, 16'h7FFF, 0, 0, 0, 0, 0, 16'h10, "R2 cmp issue");
        for (int s = 0; s < 8; s++)
            step(0, 0, 0, 1, 0, 3'(s), 8'h10, 0, 16'h20, "R5 lt state");
        step(1, 16'h7FFF, 16'h8000, 0, 0, 0, 0, 0, 16'h10, "R2 cmp gt");
        for (int s = 0; s < 8; s++)
            step(0, 0, 0, 0, 1, 3'(s), 0, 16'hBEEF, 16'h30, "R5 gt state jr");
        // R3: operands change with strobe low; flags hold
        step(0, 16'h0001, 16'h0002, 0, 0, 0, 0, 0, 16'h40, "R3 strobe low");
        step(0, 0, 0, 1, 0, 3'd6, 8'h01, 0, 16'h40, "R3 gt still held");
        // R4: compare equal and branch on gt in same cycle -> old flags
        step(1, 16'h1234, 16'h1234, 1, 0, 3'd6, 8'h02, 0, 16'h50, "R4 same cycle");
        step(0, 0, 0, 1, 0, 3'd3, 8'h02, 0, 16'h50, "R4 eq after edge");
        // R7 offsets, R9 wrap
        step(0, 0, 0, 1, 0, 3'd7, 8'h80, 0, 16'h0000, "R7 offset -128");
        step(0, 0, 0, 1, 0, 3'd7, 8'h7F, 0, 16'hFF90, "R7 offset +127 wrap");
        step(0, 0, 0, 1, 0, 3'd0, 8'h7F, 0, 16'hFFFF, "R9 pc wrap");
        // R8 / R10
        step(0, 0, 0, 0, 1, 3'd7, 8'h33, 16'hA5A5, 16'h60, "R8 jump");
        step(0, 0, 0, 1, 1, 3'd7, 8'h33, 16'h5A5A, 16'h60, "R10 both requests");
        step(0, 0, 0, 1, 1, 3'd0, 8'h33, 16'h5A5A, 16'h60, "R10 both not taken");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = ($urandom % 4 == 0) ? ra : 16'($urandom);
            step(1'($urandom % 3 == 0), ra, rb, 1'($urandom), 1'($urandom % 3 == 0),
                 3'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                 "R2 R5 R7 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule